// File: doc/BRIEF.md
# Accelerator core register and memory window slave

This block is the bus-facing side of a bank of identical convolution accelerator cores. A host on a Wishbone bus (classic single-beat cycles) reaches every core through one slave. The top address byte picks the core. Inside a core's window the low twelve address bits choose one of four regions:
- control and status registers;
- an image buffer the host can only write;
- a kernel buffer the host can only write;
- a result buffer the host can only read.

The buffers themselves sit outside the block. It drives their write strobes, word index and write data, and takes the addressed result byte back.

Each core has three registers. The control word combines commands with status. Start and soft reset are commands that clear themselves and leave as one-cycle pulses to the engine. Done and overflow are status bits that the engine sets and the host clears. The other two registers hold the geometry and post-processing fields that the engine reads continuously. Each field goes out on its own port.

Every access is acknowledged one clock after it is presented, including accesses the address map does not allow, so a host can never stall the bus.

Top module: `acc_if_top`

## Requirements
- R1: Each request (`wb_cyc_i` and `wb_stb_i` high while `wb_ack_o` is low) is acknowledged by `wb_ack_o` high for exactly one cycle, in the cycle after the request is seen. This holds for every address, including unmapped and disallowed ones.
- R2: Address byte 31:24 equal to 0x30+n, with n below `NUM_CORES` and bits 23:12 zero, selects core n. Any other address reads 0 and causes no pulse, strobe or register change in any core.
- R3: Within a core, offset bits 11:8 select the region: 0 for registers, 1 for image, 2 for kernel, 3 for result. In the register region, offset bits 7:4 must be zero and bits 3:2 pick the register. Any other offset reads 0 and writes have no effect.
- R4: A write to the image or kernel region gives a one-cycle strobe for that core (`img_we_o` or `kern_we_o`, never both) during the acknowledge cycle. In that cycle `mem_addr_o` holds address bits 7:2 and `mem_wdata_o` holds write data bits 23:0. Reads of these regions return 0.
- R5: A read of the result region drives `res_addr_o` with address bits 7:2 and returns the selected core's `res_rdata_i` byte in bits 7:0, with the upper bits zero. Writes to the result region produce no strobe.
- R6: In register 0, bit 2 is start and bit 3 is soft reset. Writing 1 to either one pulses `start_o` or `soft_rst_o` high for exactly the acknowledge cycle. Both bits read back as 0, and bits 31:4 read 0.
- R7: Register 0 bit 0 (done) is set by a `done_i` pulse. It is cleared by a write with bit 0 or bit 2 set. If `done_i` is high in the same cycle as the clearing write, the set wins.
- R8: Register 0 bit 1 (overflow) is set by `ovf_i` and stays set until a write with bit 1 set clears it. Start writes and done clears leave it untouched.
- R9: Register 1 holds the following fields, each driven on its port; the other bits read 0:
  - kernel columns in bits 2:0;
  - image columns in bits 15:8;
  - kernel count in bits 18:16;
  - stride in bits 31:24.
- R10: Register 2 holds the following fields, each driven on its port; the other bits read 0:
  - result columns in bits 7:0;
  - accumulator shift in bits 11:8;
  - kernel address mode in bit 16;
  - row mask in bits 20:18.

  Register 3 reads 0.
- R11: After reset all registers are zero, and `wb_ack_o`, every pulse and every strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 32 | Byte address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid with acknowledge |
| wb_ack_o | output | 1 | Acknowledge |
| img_we_o | output | NUM_CORES | Image buffer write strobe per core |
| kern_we_o | output | NUM_CORES | Kernel buffer write strobe per core |
| mem_addr_o | output | 6 | Word index for buffer writes |
| mem_wdata_o | output | 24 | Buffer write data |
| res_addr_o | output | 6 | Word index for result reads |
| res_rdata_i | input | 8*NUM_CORES | Result byte per core |
| start_o | output | NUM_CORES | Start pulse per core |
| soft_rst_o | output | NUM_CORES | Engine reset pulse per core |
| done_i | input | NUM_CORES | Completion pulse per core |
| ovf_i | input | NUM_CORES | Accumulator overflow per core |
| kern_cols_o | output | 3*NUM_CORES | Kernel columns field per core |
| img_cols_o | output | 8*NUM_CORES | Image columns field per core |
| kern_cnt_o | output | 3*NUM_CORES | Kernel count field per core |
| stride_o | output | 8*NUM_CORES | Stride field per core |
| res_cols_o | output | 8*NUM_CORES | Result columns field per core |
| acc_shift_o | output | 4*NUM_CORES | Accumulator shift per core |
| kern_amode_o | output | NUM_CORES | Kernel address mode per core |
| row_mask_o | output | 3*NUM_CORES | Row mask per core |

## Verification
The status and configuration state is directly visible at the ports, so a wrong bit shows up quickly:
- A status bit that is lost or set when it should not be is exposed by the next read of register 0, at most two cycles after the host issues it.
- A corrupted configuration field appears on its output port in the acknowledge cycle of the write.
- A decode fault that routes an access to the wrong core or region shows up within the same acknowledge cycle, as a stray strobe or pulse or as non-zero read data where zero is due.

// File: rtl/acc_if_pkg.sv
package acc_if_pkg;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned WIDX_W = 6;
  localparam int unsigned MEM_W  = 24;
  localparam int unsigned RES_W  = 8;

  localparam int unsigned CSR_CTRL = 0;
  localparam int unsigned CSR_GEOM = 1;
  localparam int unsigned CSR_POST = 2;

  typedef enum logic [2:0] {RG_NONE, RG_CSR, RG_IMG, RG_KERN, RG_RES} region_e;

  typedef struct packed {
    logic [7:0] stride;
    logic [2:0] kern_cnt;
    logic [7:0] img_cols;
    logic [2:0] kern_cols;
    logic [2:0] row_mask;
    logic       kern_amode;
    logic [3:0] acc_shift;
    logic [7:0] res_cols;
  } cfg_t;
endpackage

// File: rtl/acc_region_dec.sv
module acc_region_dec
  import acc_if_pkg::*;
(
  input  logic [OFF_W-1:2] word_i,
  output region_e         region_o,
  output logic [1:0]      csr_idx_o
);
  assign csr_idx_o = word_i[3:2];

  always_comb begin
    case (word_i[11:8])
      4'h0:    region_o = (word_i[7:4] == 4'h0) ? RG_CSR : RG_NONE;
      4'h1:    region_o = RG_IMG;
      4'h2:    region_o = RG_KERN;
      4'h3:    region_o = RG_RES;
      default: region_o = RG_NONE;
    endcase
  end
endmodule

// File: rtl/acc_csr_bank.sv
module acc_csr_bank
  import acc_if_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [1:0]  idx_i,
  input  logic [31:0] wdata_i,
  input  logic        done_i,
  input  logic        ovf_i,
  output logic [31:0] rdata_o,
  output logic        start_o,
  output logic        soft_rst_o,
  output cfg_t        cfg_o
);
  logic wr_ctrl, wr_geom, wr_post;
  logic start_q, srst_q, done_q, ovf_q;
  cfg_t cfg_q;
  logic unused_wdata;

  assign wr_ctrl = wr_i && (idx_i == 2'(CSR_CTRL));
  assign wr_geom = wr_i && (idx_i == 2'(CSR_GEOM));
  assign wr_post = wr_i && (idx_i == 2'(CSR_POST));
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      srst_q  <= 1'b0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      start_q <= wr_ctrl && wdata_i[2];
      srst_q  <= wr_ctrl && wdata_i[3];
      // hardware set beats software clear
      if (done_i)                                   done_q <= 1'b1;
      else if (wr_ctrl && (wdata_i[0] || wdata_i[2])) done_q <= 1'b0;
      if (ovf_i)                      ovf_q <= 1'b1;
      else if (wr_ctrl && wdata_i[1]) ovf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else begin
      if (wr_geom) begin
        cfg_q.stride    <= wdata_i[31:24];
        cfg_q.kern_cnt  <= wdata_i[18:16];
        cfg_q.img_cols  <= wdata_i[15:8];
        cfg_q.kern_cols <= wdata_i[2:0];
      end
      if (wr_post) begin
        cfg_q.row_mask   <= wdata_i[20:18];
        cfg_q.kern_amode <= wdata_i[16];
        cfg_q.acc_shift  <= wdata_i[11:8];
        cfg_q.res_cols   <= wdata_i[7:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (idx_i)
      2'(CSR_CTRL): rdata_o[3:0] = {srst_q, start_q, ovf_q, done_q};
      2'(CSR_GEOM): begin
        rdata_o[31:24] = cfg_q.stride;
        rdata_o[18:16] = cfg_q.kern_cnt;
        rdata_o[15:8]  = cfg_q.img_cols;
        rdata_o[2:0]   = cfg_q.kern_cols;
      end
      2'(CSR_POST): begin
        rdata_o[20:18] = cfg_q.row_mask;
        rdata_o[16]    = cfg_q.kern_amode;
        rdata_o[11:8]  = cfg_q.acc_shift;
        rdata_o[7:0]   = cfg_q.res_cols;
      end
      default: rdata_o = '0;
    endcase
  end

  assign start_o    = start_q;
  assign soft_rst_o = srst_q;
  assign cfg_o      = cfg_q;

  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q); // R6
  AST_SRST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> !srst_q); // R6
  AST_DONE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> done_q); // R7
  AST_DONE_CLR_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && !$past(done_i)) |-> !done_q); // R7
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(wr_ctrl && wdata_i[1])) |=> ovf_q); // R8
endmodule

// File: rtl/acc_core_port.sv
module acc_core_port
  import acc_if_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [OFF_W-1:2] word_i,
  input  logic [31:0]      wdata_i,
  input  logic [RES_W-1:0] res_rdata_i,
  input  logic             done_i,
  input  logic             ovf_i,
  output logic [31:0]      rdata_o,
  output logic             img_we_o,
  output logic             kern_we_o,
  output logic             start_o,
  output logic             soft_rst_o,
  output cfg_t             cfg_o
);
  region_e    region;
  logic [1:0] csr_idx;
  logic [31:0] csr_rdata;
  logic       csr_wr;
  logic       img_we_q, kern_we_q;

  acc_region_dec i_dec (
    .word_i    (word_i),
    .region_o  (region),
    .csr_idx_o (csr_idx)
  );

  assign csr_wr = sel_i && we_i && (region == RG_CSR);

  acc_csr_bank i_csr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (csr_wr),
    .idx_i      (csr_idx),
    .wdata_i    (wdata_i),
    .done_i     (done_i),
    .ovf_i      (ovf_i),
    .rdata_o    (csr_rdata),
    .start_o    (start_o),
    .soft_rst_o (soft_rst_o),
    .cfg_o      (cfg_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      img_we_q  <= 1'b0;
      kern_we_q <= 1'b0;
    end else begin
      img_we_q  <= sel_i && we_i && (region == RG_IMG);
      kern_we_q <= sel_i && we_i && (region == RG_KERN);
    end
  end

  always_comb begin
    case (region)
      RG_CSR:  rdata_o = csr_rdata;
      RG_RES:  rdata_o = {{(32-RES_W){1'b0}}, res_rdata_i};
      default: rdata_o = '0;
    endcase
  end

  assign img_we_o  = img_we_q;
  assign kern_we_o = kern_we_q;

  AST_ONE_BUFFER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({img_we_q, kern_we_q})); // R4
  AST_RESULT_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && (region == RG_RES)) |=> !(img_we_q || kern_we_q)); // R5
endmodule

// File: rtl/acc_if_top.sv
module acc_if_top
  import acc_if_pkg::*;
#(
  parameter int unsigned NUM_CORES = 11,
  parameter logic [7:0]  BASE_SEL  = 8'h30
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wb_cyc_i,
  input  logic                       wb_stb_i,
  input  logic                       wb_we_i,
  input  logic [31:0]                wb_adr_i,
  input  logic [31:0]                wb_dat_i,
  output logic [31:0]                wb_dat_o,
  output logic                       wb_ack_o,
  output logic [NUM_CORES-1:0]       img_we_o,
  output logic [NUM_CORES-1:0]       kern_we_o,
  output logic [WIDX_W-1:0]          mem_addr_o,
  output logic [MEM_W-1:0]           mem_wdata_o,
  output logic [WIDX_W-1:0]          res_addr_o,
  input  logic [NUM_CORES*RES_W-1:0] res_rdata_i,
  output logic [NUM_CORES-1:0]       start_o,
  output logic [NUM_CORES-1:0]       soft_rst_o,
  input  logic [NUM_CORES-1:0]       done_i,
  input  logic [NUM_CORES-1:0]       ovf_i,
  output logic [NUM_CORES*3-1:0]     kern_cols_o,
  output logic [NUM_CORES*8-1:0]     img_cols_o,
  output logic [NUM_CORES*3-1:0]     kern_cnt_o,
  output logic [NUM_CORES*8-1:0]     stride_o,
  output logic [NUM_CORES*8-1:0]     res_cols_o,
  output logic [NUM_CORES*4-1:0]     acc_shift_o,
  output logic [NUM_CORES-1:0]       kern_amode_o,
  output logic [NUM_CORES*3-1:0]     row_mask_o
);
  logic                 accept, ack_q, in_win;
  logic [7:0]           sel_byte;
  logic [NUM_CORES-1:0] hit, core_sel;
  logic [31:0]          core_rdata [NUM_CORES];
  cfg_t                 core_cfg   [NUM_CORES];
  logic [31:0]          rd_mux, rdata_q;
  logic [WIDX_W-1:0]    mem_addr_q;
  logic [MEM_W-1:0]     mem_wdata_q;
  logic                 unused_adr;

  assign accept     = wb_cyc_i && wb_stb_i && !ack_q;
  assign sel_byte   = wb_adr_i[31:24];
  assign in_win     = (wb_adr_i[23:OFF_W] == '0);
  assign core_sel   = hit & {NUM_CORES{accept}};
  assign unused_adr = ^wb_adr_i[1:0];

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    localparam logic [7:0] SEL_G = 8'(BASE_SEL + g);
    assign hit[g] = in_win && (sel_byte == SEL_G);

    acc_core_port i_core (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sel_i       (core_sel[g]),
      .we_i        (wb_we_i),
      .word_i      (wb_adr_i[OFF_W-1:2]),
      .wdata_i     (wb_dat_i),
      .res_rdata_i (res_rdata_i[g*RES_W +: RES_W]),
      .done_i      (done_i[g]),
      .ovf_i       (ovf_i[g]),
      .rdata_o     (core_rdata[g]),
      .img_we_o    (img_we_o[g]),
      .kern_we_o   (kern_we_o[g]),
      .start_o     (start_o[g]),
      .soft_rst_o  (soft_rst_o[g]),
      .cfg_o       (core_cfg[g])
    );

    assign kern_cols_o[g*3 +: 3]  = core_cfg[g].kern_cols;
    assign img_cols_o[g*8 +: 8]   = core_cfg[g].img_cols;
    assign kern_cnt_o[g*3 +: 3]   = core_cfg[g].kern_cnt;
    assign stride_o[g*8 +: 8]     = core_cfg[g].stride;
    assign res_cols_o[g*8 +: 8]   = core_cfg[g].res_cols;
    assign acc_shift_o[g*4 +: 4]  = core_cfg[g].acc_shift;
    assign kern_amode_o[g]        = core_cfg[g].kern_amode;
    assign row_mask_o[g*3 +: 3]   = core_cfg[g].row_mask;
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (hit[i]) rd_mux = rd_mux | core_rdata[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q       <= 1'b0;
      rdata_q     <= '0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
    end else begin
      ack_q <= accept;
      if (accept) rdata_q <= rd_mux;
      if (accept && wb_we_i) begin
        mem_addr_q  <= wb_adr_i[WIDX_W+1:2];
        mem_wdata_q <= wb_dat_i[MEM_W-1:0];
      end
    end
  end

  assign wb_ack_o    = ack_q;
  assign wb_dat_o    = rdata_q;
  assign mem_addr_o  = mem_addr_q;
  assign mem_wdata_o = mem_wdata_q;
  assign res_addr_o  = wb_adr_i[WIDX_W+1:2];

  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o); // R1
  AST_UNMAPPED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !(|hit)) |=> !(|{start_o, soft_rst_o, img_we_o, kern_we_o})); // R2
  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !wb_we_i && !(|hit)) |=> (wb_dat_o == '0)); // R2
endmodule

// File: tb/test_acc_if_top.sv
module test_acc_if_top;
  localparam int NC = 11;
  localparam logic [31:0] C0  = 32'h3000_0000;
  localparam logic [31:0] C10 = 32'h3A00_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic wb_cyc = 0, wb_stb = 0, wb_we = 0;
  logic [31:0] wb_adr = '0, wb_wdat = '0;
  logic [31:0] wb_rdat;
  logic wb_ack;
  logic [NC-1:0] img_we, kern_we, start, srst;
  logic [NC-1:0] done = '0, ovf = '0;
  logic [5:0] mem_addr, res_addr;
  logic [23:0] mem_wdata;
  logic [NC*8-1:0] res_rdata;
  logic [NC*3-1:0] kern_cols, kern_cnt, row_mask;
  logic [NC*8-1:0] img_cols, stride, res_cols;
  logic [NC*4-1:0] acc_shift;
  logic [NC-1:0] kern_amode;

  for (genvar k = 0; k < NC; k++) begin : g_res
    assign res_rdata[k*8 +: 8] = 8'(k*17) + 8'(res_addr*3) + 8'd1;
  end

  acc_if_top #(.NUM_CORES(NC)) i_acc_if_top (
    .clk_i(clk), .rst_ni(rst_n), .wb_cyc_i(wb_cyc), .wb_stb_i(wb_stb), .wb_we_i(wb_we),
    .wb_adr_i(wb_adr), .wb_dat_i(wb_wdat), .wb_dat_o(wb_rdat), .wb_ack_o(wb_ack),
    .img_we_o(img_we), .kern_we_o(kern_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .res_addr_o(res_addr), .res_rdata_i(res_rdata), .start_o(start), .soft_rst_o(srst),
    .done_i(done), .ovf_i(ovf), .kern_cols_o(kern_cols), .img_cols_o(img_cols),
    .kern_cnt_o(kern_cnt), .stride_o(stride), .res_cols_o(res_cols), .acc_shift_o(acc_shift),
    .kern_amode_o(kern_amode), .row_mask_o(row_mask)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit rd_pend = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic [NC-1:0] s_img, s_kern, s_start, s_srst;
  logic [5:0] s_addr;
  logic [23:0] s_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one bus cycle; reads push their expectation to the scoreboard
  task automatic bus(input logic we, input logic [31:0] adr, input logic [31:0] dat,
                     input logic [31:0] exp, input string tag);
    @(negedge clk);
    chk("R1 ack idle before request", 32'(wb_ack), 32'd0);
    wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = adr; wb_wdat = dat;
    if (!we) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      rd_pend = 1;
    end
    @(negedge clk);
    chk("R1 ack one cycle after request", 32'(wb_ack), 32'd1);
    s_img = img_we; s_kern = kern_we; s_start = start; s_srst = srst;
    s_addr = mem_addr; s_wdata = mem_wdata;
    #2;
    wb_cyc = 0; wb_stb = 0; wb_we = 0; rd_pend = 0;
  endtask

  // monitor: compares read data in the acknowledge cycle
  always @(negedge clk) begin
    if (rst_n && wb_ack && rd_pend) begin
      if (exp_q.size() == 0) begin
        chk("scoreboard underflow", 32'd1, 32'd0);
      end else begin
        chk(tag_q.pop_front(), wb_rdat, exp_q.pop_front());
      end
    end
  end

  task automatic pulse_done(input int core);
    @(negedge clk); done[core] = 1'b1;
    @(negedge clk); done[core] = 1'b0;
  endtask

  task automatic pulse_ovf(input int core);
    @(negedge clk); ovf[core] = 1'b1;
    @(negedge clk); ovf[core] = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11 ack", 32'(wb_ack), 0);
    chk("R11 start", 32'(start), 0);
    chk("R11 soft reset", 32'(srst), 0);
    chk("R11 strobes", 32'({img_we, kern_we}), 0);
    chk("R11 stride", stride[31:0], 0);
    chk("R11 row mask", 32'(row_mask[2:0]), 0);
    rst_n = 1'b1;
    bus(0, C0 + 0, 0, 32'h0, "R11 reg0 after reset");
    bus(0, C0 + 4, 0, 32'h0, "R11 reg1 after reset");
    bus(0, C0 + 8, 0, 32'h0, "R11 reg2 after reset");

    // R9 geometry register
    bus(1, C0 + 4, 32'h5A0F_3C7D, 0, "");
    chk("R9 stride port", 32'(stride[7:0]), 32'h5A);
    chk("R9 kernel count port", 32'(kern_cnt[2:0]), 32'd7);
    chk("R9 image cols port", 32'(img_cols[7:0]), 32'h3C);
    chk("R9 kernel cols port", 32'(kern_cols[2:0]), 32'd5);
    bus(0, C0 + 4, 0, 32'h5A07_3C05, "R9 readback reserved zero");

    // R10 post-processing register
    bus(1, C0 + 8, 32'hFFFF_FFFF, 0, "");
    bus(0, C0 + 8, 0, 32'h001D_0FFF, "R10 readback all ones");
    bus(1, C0 + 8, 32'h0014_0A33, 0, "");
    chk("R10 row mask port", 32'(row_mask[2:0]), 32'd5);
    chk("R10 address mode port", 32'(kern_amode[0]), 32'd0);
    chk("R10 shift port", 32'(acc_shift[3:0]), 32'hA);
    chk("R10 result cols port", 32'(res_cols[7:0]), 32'h33);
    bus(0, C0 + 8, 0, 32'h0014_0A33, "R10 readback");
    bus(0, C0 + 12, 0, 32'h0, "R10 reg3 reads zero");
    bus(0, C0 + 32'h10, 0, 32'h0, "R3 offset 0x010 reads zero");

    // R2 core isolation
    bus(1, C10 + 4, 32'h0102_0304, 0, "");
    chk("R2 core10 stride port", 32'(stride[10*8 +: 8]), 32'h01);
    bus(0, C10 + 4, 0, 32'h0102_0304, "R2 core10 reg1");
    bus(0, C0 + 4, 0, 32'h5A07_3C05, "R2 core0 reg1 untouched");

    // R6 start and soft reset pulses
    bus(1, C0, 32'h4, 0, "");
    chk("R6 start pulse core0", 32'(s_start), 32'h1);
    chk("R6 no soft reset on start", 32'(s_srst), 32'h0);
    @(negedge clk);
    chk("R6 start one cycle", 32'(start), 32'h0);
    bus(0, C0, 0, 32'h0, "R6 start reads zero");
    bus(1, C0, 32'h8, 0, "");
    chk("R6 soft reset pulse", 32'(s_srst), 32'h1);
    chk("R6 no start on soft reset", 32'(s_start), 32'h0);
    @(negedge clk);
    chk("R6 soft reset one cycle", 32'(srst), 32'h0);

    // R7 done
    pulse_done(0);
    bus(0, C0, 0, 32'h1, "R7 done set");
    bus(1, C0, 32'h1, 0, "");
    bus(0, C0, 0, 32'h0, "R7 done cleared by write one");
    pulse_done(0);
    bus(0, C0, 0, 32'h1, "R7 done set again");
    bus(1, C0, 32'h4, 0, "");
    bus(0, C0, 0, 32'h0, "R7 done cleared by start");
    done[0] = 1'b1;
    bus(1, C0, 32'h4, 0, "");
    done[0] = 1'b0;
    chk("R7 start pulse in collision", 32'(s_start), 32'h1);
    bus(0, C0, 0, 32'h1, "R7 set wins over start clear");
    bus(1, C0, 32'h1, 0, "");

    // R8 overflow
    pulse_ovf(0);
    bus(0, C0, 0, 32'h2, "R8 overflow set");
    bus(1, C0, 32'h4, 0, "");
    bus(0, C0, 0, 32'h2, "R8 start keeps overflow");
    bus(1, C0, 32'h1, 0, "");
    bus(0, C0, 0, 32'h2, "R8 done clear keeps overflow");
    bus(1, C0, 32'h2, 0, "");
    bus(0, C0, 0, 32'h0, "R8 overflow cleared");

    // R4 buffer writes
    bus(1, C0 + 32'h114, 32'hAABB_CCDD, 0, "");
    chk("R4 image strobe", 32'(s_img), 32'h1);
    chk("R4 no kernel strobe", 32'(s_kern), 32'h0);
    chk("R4 word index", 32'(s_addr), 32'd5);
    chk("R4 write data", 32'(s_wdata), 32'hBB_CCDD);
    @(negedge clk);
    chk("R4 image strobe one cycle", 32'(img_we), 32'h0);
    bus(0, C0 + 32'h114, 0, 32'h0, "R4 image reads zero");
    bus(1, C10 + 32'h208, 32'h0012_3456, 0, "");
    chk("R4 kernel strobe core10", 32'(s_kern), 32'h400);
    chk("R4 no image strobe", 32'(s_img), 32'h0);
    chk("R4 kernel word index", 32'(s_addr), 32'd2);
    chk("R4 kernel data", 32'(s_wdata), 32'h12_3456);
    bus(0, C10 + 32'h208, 0, 32'h0, "R4 kernel reads zero");

    // R5 result reads
    bus(0, C10 + 32'h30C, 0, 32'h0000_00B4, "R5 core10 result word 3");
    bus(0, C0 + 32'h3FC, 0, 32'h0000_00BE, "R5 core0 result word 63");
    bus(1, C0 + 32'h304, 32'hFF, 0, "");
    chk("R5 result write no strobe", 32'({s_img, s_kern}), 32'h0);

    // R3 offsets beyond the map
    bus(0, C0 + 32'h404, 0, 32'h0, "R3 offset 0x404 reads zero");
    bus(1, C0 + 32'h404, 32'hF, 0, "");
    chk("R3 offset 0x404 write quiet", 32'({s_img, s_kern, s_start, s_srst}), 32'h0);

    // R2 unmapped cores and windows
    bus(0, 32'h3B00_0004, 0, 32'h0, "R2 core 11 reads zero");
    bus(0, 32'h2F00_0004, 0, 32'h0, "R2 below base reads zero");
    bus(0, 32'h3000_1004, 0, 32'h0, "R2 outside window reads zero");
    bus(1, 32'h3000_1000, 32'hC, 0, "");
    chk("R2 alias write no pulse", 32'({s_start, s_srst}), 32'h0);
    bus(1, 32'h3B00_0000, 32'hC, 0, "");
    chk("R2 core 11 write no pulse", 32'({s_start, s_srst}), 32'h0);
    bus(0, C0 + 4, 0, 32'h5A07_3C05, "R2 core0 config intact");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", 32'(exp_q.size()), 32'd0);
    summary();
  end
endmodule